// File: doc/BRIEF.md
# Store Set Dependence Predictor

This block predicts which in-flight store a memory instruction must wait for in an out-of-order core. Load and store program counters are grouped into sets, and each set remembers its youngest in-flight store. When an instruction is fetched, the block looks up its set and returns the tag of the store it must wait on, if there is one. Stores of the same set are chained: each new store waits on the one fetched before it.

Two untagged direct-mapped tables hold the state. The first is indexed by program counter bits and gives a set number. The second is indexed by set number and holds the tag of the youngest in-flight store. Store issue removes a store from its set's entry. Violation reports from the memory pipeline train the first table, either by allocating a fresh set or by joining or merging existing ones. A flush input wipes all in-flight store records after a squash. The issue queue and its wakeup logic, and address comparison, live outside this block.

Top module: `store_set_predictor`

## Requirements
- R1: A violation in which neither the load PC nor the store PC has a set allocates a fresh set number and writes it for both PCs. Fresh numbers are handed out in increasing order from 0 after reset and wrap modulo the number of sets.
- R2: A violation in which exactly one of the two PCs has a set writes that set number for the other PC.
- R3: A fetched store whose PC has a set returns the set's recorded store, if valid, on `dep_valid`/`dep_tag` in the same cycle. From the next cycle the set records the new store's tag.
- R4: A store issue clears its set's record only when the recorded tag equals the issued tag. Otherwise the record is unchanged.
- R5: A fetched load whose PC has a set with a valid record sees `dep_valid`=1 and `dep_tag` equal to that record. In every other case, and whenever `fetch_valid`=0, `dep_valid` is 0.
- R6: `flush` clears every store record at the clock edge. In the flush cycle `dep_valid` is 0 and a fetched store records nothing.
- R7: A violation between PCs that have two different sets writes the smaller set number for both PCs. Equal sets cause no change.
- R8: The set table is indexed by PC bits [11:2] with no tag, so PCs that differ only above bit 11 share one entry.
- R9: When an issue clears the record of the same set that a fetch looks up in that cycle, `dep_valid` is 0. A store fetch and a clearing issue on one set in the same cycle leave the fetched store recorded.
- R10: After reset no PC has a set and no record is valid, so no fetch sees a dependence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A memory instruction is fetched this cycle |
| fetch_is_store | input | 1 | 1 for a store, 0 for a load |
| fetch_pc | input | PC_W | PC of the fetched instruction |
| fetch_tag | input | TAG_W | In-flight tag of the fetched store |
| issue_valid | input | 1 | A store issues this cycle |
| issue_pc | input | PC_W | PC of the issuing store |
| issue_tag | input | TAG_W | Tag of the issuing store |
| viol_valid | input | 1 | An ordering violation is reported |
| viol_load_pc | input | PC_W | PC of the violating load |
| viol_store_pc | input | PC_W | PC of the violated store |
| flush | input | 1 | Squash: drop all store records |
| dep_valid | output | 1 | The fetched instruction must wait on a store |
| dep_tag | output | TAG_W | Tag of the store to wait on |

## Verification
Store issue and store fetch can both touch the record of one set in the same cycle. Directed steps provoke this: a store is fetched, and in the next cycle it issues while another instance of the same PC is fetched. The bench expects no dependence in that cycle and then expects the new store as the predecessor of a following load. Random stimulus with a small PC pool and frequent issues makes such collisions, including flush and violation in the same cycle, recur. Every cycle is judged against a bench model that applies the requirements' update order.

// File: rtl/store_set_predictor.sv
module store_set_predictor #(
  parameter int PC_W       = 32,
  parameter int PC_LSB     = 2,
  parameter int SSIT_DEPTH = 1024,
  parameter int NUM_SETS   = 128,
  parameter int TAG_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  input  logic             fetch_is_store,
  input  logic [PC_W-1:0]  fetch_pc,
  input  logic [TAG_W-1:0] fetch_tag,
  input  logic             issue_valid,
  input  logic [PC_W-1:0]  issue_pc,
  input  logic [TAG_W-1:0] issue_tag,
  input  logic             viol_valid,
  input  logic [PC_W-1:0]  viol_load_pc,
  input  logic [PC_W-1:0]  viol_store_pc,
  input  logic             flush,
  output logic             dep_valid,
  output logic [TAG_W-1:0] dep_tag
);
  localparam int IDX_W = $clog2(SSIT_DEPTH);
  localparam int ID_W  = $clog2(NUM_SETS);

  logic [SSIT_DEPTH-1:0] ssit_v;
  logic [ID_W-1:0]       ssit_id [SSIT_DEPTH];
  logic [NUM_SETS-1:0]   lfst_v;
  logic [TAG_W-1:0]      lfst_tag [NUM_SETS];
  logic [ID_W-1:0]       next_id;

  wire [IDX_W-1:0] f_idx = fetch_pc[PC_LSB +: IDX_W];
  wire [IDX_W-1:0] i_idx = issue_pc[PC_LSB +: IDX_W];
  wire [IDX_W-1:0] l_idx = viol_load_pc[PC_LSB +: IDX_W];
  wire [IDX_W-1:0] s_idx = viol_store_pc[PC_LSB +: IDX_W];

  wire            f_hit = ssit_v[f_idx];
  wire [ID_W-1:0] f_id  = ssit_id[f_idx];
  wire            i_hit = ssit_v[i_idx];
  wire [ID_W-1:0] i_id  = ssit_id[i_idx];
  wire            l_hit = ssit_v[l_idx];
  wire [ID_W-1:0] l_id  = ssit_id[l_idx];
  wire            s_hit = ssit_v[s_idx];
  wire [ID_W-1:0] s_id  = ssit_id[s_idx];

  wire iclr  = issue_valid & i_hit & lfst_v[i_id] & (lfst_tag[i_id] == issue_tag);
  wire st_wr = fetch_valid & fetch_is_store & f_hit & ~flush;

  assign dep_valid = fetch_valid & ~flush & f_hit & lfst_v[f_id] & ~(iclr & (i_id == f_id));
  assign dep_tag   = lfst_tag[f_id];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfst_v <= '0;
    end else if (flush) begin
      lfst_v <= '0;
    end else begin
      if (iclr) lfst_v[i_id] <= 1'b0;
      if (st_wr) begin
        lfst_v[f_id]   <= 1'b1;
        lfst_tag[f_id] <= fetch_tag;
      end
    end
  end

  logic            wr_l, wr_s, bump;
  logic [ID_W-1:0] wr_id;

  always_comb begin
    wr_l  = 1'b0;
    wr_s  = 1'b0;
    bump  = 1'b0;
    wr_id = next_id;
    if (viol_valid) begin
      case ({l_hit, s_hit})
        2'b00: begin wr_l = 1'b1; wr_s = 1'b1; bump = 1'b1; end
        2'b10: begin wr_s = 1'b1; wr_id = l_id; end
        2'b01: begin wr_l = 1'b1; wr_id = s_id; end
        default: begin
          if (l_id != s_id) begin
            wr_l  = 1'b1;
            wr_s  = 1'b1;
            wr_id = (l_id < s_id) ? l_id : s_id;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ssit_v  <= '0;
      next_id <= '0;
    end else begin
      if (wr_l) begin
        ssit_v[l_idx]  <= 1'b1;
        ssit_id[l_idx] <= wr_id;
      end
      if (wr_s) begin
        ssit_v[s_idx]  <= 1'b1;
        ssit_id[s_idx] <= wr_id;
      end
      if (bump) next_id <= next_id + 1'b1;
    end
  end
endmodule

module store_set_predictor_chk #(
  parameter int PC_W  = 32,
  parameter int TAG_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_valid,
  input logic             fetch_is_store,
  input logic [PC_W-1:0]  fetch_pc,
  input logic [TAG_W-1:0] fetch_tag,
  input logic             issue_valid,
  input logic [PC_W-1:0]  issue_pc,
  input logic [TAG_W-1:0] issue_tag,
  input logic             viol_valid,
  input logic             flush,
  input logic             dep_valid,
  input logic [TAG_W-1:0] dep_tag,
  input logic             f_hit
);
  // R5
  a_r5_idle_no_dep: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |-> !dep_valid);

  // R6
  a_r6_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !dep_valid);

  // R3
  a_r3_store_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !flush && !issue_valid && $past(rst_n) &&
     $past(fetch_valid && fetch_is_store && f_hit && !flush && !viol_valid) &&
     fetch_pc == $past(fetch_pc))
    |-> (dep_valid && dep_tag == $past(fetch_tag)));

  // R9
  a_r9_issue_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && issue_valid && fetch_pc == issue_pc && !flush && $past(rst_n) &&
     $past(fetch_valid && fetch_is_store && f_hit && !flush && !viol_valid && !issue_valid) &&
     $past(fetch_pc) == issue_pc && $past(fetch_tag) == issue_tag)
    |-> !dep_valid);
endmodule

bind store_set_predictor store_set_predictor_chk #(.PC_W(PC_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_is_store(fetch_is_store),
  .fetch_pc(fetch_pc), .fetch_tag(fetch_tag), .issue_valid(issue_valid),
  .issue_pc(issue_pc), .issue_tag(issue_tag), .viol_valid(viol_valid), .flush(flush),
  .dep_valid(dep_valid), .dep_tag(dep_tag), .f_hit(f_hit)
);

// File: tb/store_set_predictor_bench.sv
module store_set_predictor_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 0, fetch_is_store = 0;
  logic [31:0] fetch_pc = 0;
  logic [5:0]  fetch_tag = 0;
  logic        issue_valid = 0;
  logic [31:0] issue_pc = 0;
  logic [5:0]  issue_tag = 0;
  logic        viol_valid = 0;
  logic [31:0] viol_load_pc = 0, viol_store_pc = 0;
  logic        flush = 0;
  logic        dep_valid;
  logic [5:0]  dep_tag;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  store_set_predictor u_store_set_predictor (.*);

  bit       m_sv [1024];
  bit [6:0] m_sid [1024];
  bit       m_lv [128];
  bit [5:0] m_lt [128];
  bit [6:0] m_next;

  function automatic int ix(input logic [31:0] pc);
    return int'(pc[11:2]);
  endfunction

  task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, got, exp);
    end
  endtask

  task automatic cyc(input bit fv, input bit fs, input logic [31:0] fpc, input logic [5:0] ft,
                     input bit iv, input logic [31:0] ipc, input logic [5:0] it,
                     input bit vv, input logic [31:0] vl, input logic [31:0] vs, input bit fl);
    bit fh, ih, lh, sh, iclr, ev;
    bit [6:0] fid, iid, lid, sid, m;
    @(negedge clk);
    fetch_valid = fv; fetch_is_store = fs; fetch_pc = fpc; fetch_tag = ft;
    issue_valid = iv; issue_pc = ipc; issue_tag = it;
    viol_valid = vv; viol_load_pc = vl; viol_store_pc = vs; flush = fl;
    #1;
    fh = m_sv[ix(fpc)]; fid = m_sid[ix(fpc)];
    ih = m_sv[ix(ipc)]; iid = m_sid[ix(ipc)];
    iclr = iv && ih && m_lv[iid] && m_lt[iid] == it;
    ev = fv && !fl && fh && m_lv[fid] && !(iclr && iid == fid);
    chk(fs ? "R3 model dep_valid" : "R5 model dep_valid", dep_valid, ev);
    if (ev) chk(fs ? "R3 model dep_tag" : "R5 model dep_tag", dep_tag, m_lt[fid]);
    if (fl) begin
      for (int k = 0; k < 128; k++) m_lv[k] = 0;
    end else begin
      if (iclr) m_lv[iid] = 0;
      if (fv && fs && fh) begin m_lv[fid] = 1; m_lt[fid] = ft; end
    end
    if (vv) begin
      lh = m_sv[ix(vl)]; lid = m_sid[ix(vl)];
      sh = m_sv[ix(vs)]; sid = m_sid[ix(vs)];
      if (!lh && !sh) begin
        m_sv[ix(vl)] = 1; m_sid[ix(vl)] = m_next;
        m_sv[ix(vs)] = 1; m_sid[ix(vs)] = m_next;
        m_next++;
      end else if (lh && !sh) begin
        m_sv[ix(vs)] = 1; m_sid[ix(vs)] = lid;
      end else if (!lh && sh) begin
        m_sv[ix(vl)] = 1; m_sid[ix(vl)] = sid;
      end else if (lid != sid) begin
        m = (lid < sid) ? lid : sid;
        m_sid[ix(vl)] = m; m_sid[ix(vs)] = m;
      end
    end
  endtask

  task automatic ld(input logic [31:0] pc);
    cyc(1, 0, pc, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic st(input logic [31:0] pc, input logic [5:0] t);
    cyc(1, 1, pc, t, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic iss(input logic [31:0] pc, input logic [5:0] t);
    cyc(0, 0, 0, 0, 1, pc, t, 0, 0, 0, 0);
  endtask
  task automatic vio(input logic [31:0] l, input logic [31:0] s);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, l, s, 0);
  endtask

  localparam logic [31:0] PA = 32'h100, PB = 32'h104, PC = 32'h108;
  localparam logic [31:0] SS = 32'h200, ST = 32'h204;

  initial begin
    logic [31:0] rpc [4];
    logic [5:0]  rtg [4];
    logic [5:0]  tg;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    ld(PA);        chk("R10 no dep after reset", dep_valid, 0);
    st(SS, 1);     chk("R10 store no set", dep_valid, 0);
    vio(PA, SS);
    st(SS, 5);     chk("R3 first store of set", dep_valid, 0);
    ld(PA);        chk("R1 load joined new set", dep_valid, 1); chk("R5 load tag", dep_tag, 5);
    st(SS, 6);     chk("R3 predecessor valid", dep_valid, 1); chk("R3 predecessor tag", dep_tag, 5);
    ld(PA);        chk("R5 load follows youngest", dep_tag, 6);
    iss(SS, 5);
    ld(PA);        chk("R4 stale issue ignored", dep_valid, 1); chk("R4 record kept", dep_tag, 6);
    iss(SS, 6);
    ld(PA);        chk("R4 issue clears record", dep_valid, 0);
    vio(PB, SS);
    st(SS, 7);
    ld(PB);        chk("R2 load joins store set", dep_valid, 1); chk("R2 tag", dep_tag, 7);
    vio(PC, ST);
    st(ST, 9);
    ld(PC);        chk("R1 second set allocated", dep_tag, 9);
    vio(PC, SS);
    ld(PC);        chk("R7 merged to smaller id", dep_valid, 1); chk("R7 tag", dep_tag, 7);
    cyc(1, 1, SS, 10, 0, 0, 0, 0, 0, 0, 1); chk("R6 flush cycle no dep", dep_valid, 0);
    ld(PB);        chk("R6 records cleared", dep_valid, 0);
    st(SS, 11);
    cyc(1, 0, PB, 0, 1, SS, 11, 0, 0, 0, 0); chk("R9 issue bypass load", dep_valid, 0);
    ld(PB);        chk("R9 cleared afterwards", dep_valid, 0);
    st(SS, 12);
    cyc(1, 1, SS, 13, 1, SS, 12, 0, 0, 0, 0); chk("R9 issue bypass store", dep_valid, 0);
    ld(PB);        chk("R9 fetch write wins", dep_valid, 1); chk("R9 tag", dep_tag, 13);
    ld(PA + 32'h1000); chk("R8 alias shares entry", dep_valid, 1); chk("R8 tag", dep_tag, 13);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); chk("R5 idle no dep", dep_valid, 0);

    tg = 20;
    for (int k = 0; k < 4; k++) begin rpc[k] = SS; rtg[k] = 0; end
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] p, vl, vs;
      bit fv, fs, iv, vv, fl;
      int j;
      p  = 32'h100 + 4 * ($urandom % 12) + (($urandom % 8 == 0) ? 32'h1000 : 0);
      vl = 32'h100 + 4 * ($urandom % 12);
      vs = 32'h100 + 4 * ($urandom % 12);
      fv = ($urandom % 4) != 0;
      fs = $urandom % 2;
      iv = ($urandom % 3) == 0;
      vv = ($urandom % 12) == 0;
      fl = ($urandom % 80) == 0;
      j  = $urandom % 4;
      cyc(fv, fs, p, tg, iv, rpc[j], rtg[j], vv, vl, vs, fl);
      if (fv && fs) begin
        rpc[n % 4] = p; rtg[n % 4] = tg; tg++;
      end
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule